// File: doc/BRIEF.md
# Diode-Matrix Key Decoder with Chord Rules

This block turns the levels on up to six key input lines into a status word with one bit per key. A key either drives a single line active, or, wired through a pair of diodes, drives two lines active together; each such two-line combination is its own key. With n lines in use there are n single keys and n(n-1)/2 pair keys, so 6, 10, 15 or 21 keys for 3, 4, 5 or 6 lines.

Every line is debounced: a new level is accepted only after it has been seen on three consecutive sample ticks. A pair key is recognised only when both of its lines become active on the same accepted tick. Once it is recognised, it holds a lock: single-key information is suppressed and further line activity is ignored until both of its lines are released. Keys pressed one after another are reported as several held single keys. A one-clock change flag marks every update of the status word.

Top module: `keymx_decoder`

## Requirements
- R1: While reset is asserted and after it is released, `keys_o` is all zero and `changed_o` is low.
- R2: A line level is accepted only after it has been sampled at the new value on 3 consecutive `tick_i` pulses; a shorter excursion leaves `keys_o` unchanged.
- R3: Line k is treated as inactive while k >= `line_cnt_i`; when the count rises to include a line that is already held active, that line is reported as a new press.
- R4: An accepted rise of line k alone sets `keys_o[k]` (bits 0 to 5 are the single keys, bit index = line number); an accepted fall of line k clears it.
- R5: Two lines a < b rising on the same accepted tick set only pair bit 6 + sum over m < a of (5 - m) + (b - a - 1), so (0,1)=6, (1,3)=12, (2,4)=16, (4,5)=20.
- R6: A line rising while another line is already held is reported as a single key, never as a pair with the held line.
- R7: While a pair bit is set, every single-key bit is zero.
- R8: If three or more lines rise together, only the pair of the two lowest-numbered lines is reported; at most one pair bit is ever set, and lines pressed while the pair is held are ignored.
- R9: The pair bit clears when both of its lines are released; when no line is active, all status bits are zero and the lock is released, so a following single press is reported.
- R10: `changed_o` is high for exactly one clock in the cycle that `keys_o` takes a new value, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lines_i | input | 6 | Raw line levels, 1 = active |
| tick_i | input | 1 | Sample strobe for debouncing, one clock wide |
| line_cnt_i | input | 3 | Number of lines in use (lines at or above it are inactive) |
| keys_o | output | 21 | Key status, singles in bits 0..5, pairs in bits 6..20 |
| changed_o | output | 1 | One-clock pulse when `keys_o` changes |

## Verification
A debounce counter stuck or reset at the wrong time shows as a key bit that appears one tick early, one tick late, or after a glitch, visible two clocks after the deciding tick. A chord lock that fails to set or release shows as single bits leaking beside a pair bit, a second pair bit, or a press ignored after full release, at the next accepted line change. Every change of `keys_o` is matched against an ordered list of expected words, so an extra, missing or wrong update is reported when the flag fires.

// File: rtl/keymx_pkg.sv
package keymx_pkg;
  // bit position of the pair key (a < b) in the status word
  function automatic int pair_index(int nl, int a, int b);
    int idx;
    idx = nl;
    for (int m = 0; m < a; m++) idx += nl - 1 - m;
    return idx + (b - a - 1);
  endfunction
endpackage

// File: rtl/keymx_debounce.sv
module keymx_debounce #(
  parameter int NL           = 6,
  parameter int STABLE_TICKS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [NL-1:0] raw_i,
  output logic [NL-1:0] stable_o
);
  localparam int CW = $clog2(STABLE_TICKS + 1);

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q       <= '0;
        stable_o[g] <= 1'b0;
      end else if (tick_i) begin
        if (raw_i[g] != stable_o[g]) begin
          if (cnt_q == CW'(STABLE_TICKS - 1)) begin
            stable_o[g] <= raw_i[g];
            cnt_q       <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end
  end

  assert_tick_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(stable_o));
endmodule

// File: rtl/keymx_chord.sv
module keymx_chord #(
  parameter int NL = 6,
  parameter int NK = NL + NL * (NL - 1) / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NL-1:0] act_i,
  output logic [NK-1:0] keys_o,
  output logic          changed_o
);
  import keymx_pkg::*;
  localparam int IW = (NL > 1) ? $clog2(NL) : 1;

  logic [NL-1:0] act_q, rise, fall;
  logic [NK-1:0] keys_q, keys_n;
  logic          lock_q, lock_n, chg_q;
  logic [IW-1:0] pa_q, pb_q, pa_n, pb_n;
  int            lo, hi;

  assign rise = act_i & ~act_q;
  assign fall = ~act_i & act_q;

  always_comb begin
    keys_n = keys_q;
    lock_n = lock_q;
    pa_n   = pa_q;
    pb_n   = pb_q;
    lo     = 0;
    hi     = 0;
    for (int k = NL - 1; k >= 0; k--) begin
      if (rise[k]) begin
        hi = lo;
        lo = k;
      end
    end
    if (act_i == '0) begin
      keys_n = '0;
      lock_n = 1'b0;
    end else if (lock_q) begin
      // pair held: everything else is ignored until both pair lines drop
      if (!(act_i[pa_q] || act_i[pb_q])) begin
        keys_n = '0;
        lock_n = 1'b0;
      end
    end else if ($countones(rise) >= 2) begin
      keys_n = '0;
      keys_n[pair_index(NL, lo, hi)] = 1'b1;
      lock_n = 1'b1;
      pa_n   = IW'(lo);
      pb_n   = IW'(hi);
    end else begin
      keys_n[NL-1:0] = (keys_q[NL-1:0] & ~fall) | rise;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      keys_q <= '0;
      lock_q <= 1'b0;
      pa_q   <= '0;
      pb_q   <= '0;
      chg_q  <= 1'b0;
    end else begin
      act_q  <= act_i;
      keys_q <= keys_n;
      lock_q <= lock_n;
      pa_q   <= pa_n;
      pb_q   <= pb_n;
      chg_q  <= (keys_n != keys_q);
    end
  end

  assign keys_o    = keys_q;
  assign changed_o = chg_q;

  assert_one_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(keys_q[NK-1:NL]));
  assert_pair_hides_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|keys_q[NK-1:NL]) |-> (keys_q[NL-1:0] == '0));
  assert_idle_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == '0) |=> (keys_q == '0 && !lock_q));
  assert_flag_tracks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q == (keys_q != $past(keys_q)));
endmodule

// File: rtl/keymx_decoder.sv
module keymx_decoder #(
  parameter int NL           = 6,
  parameter int STABLE_TICKS = 3,
  localparam int NK          = NL + NL * (NL - 1) / 2,
  localparam int CNTW        = $clog2(NL + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NL-1:0]   lines_i,
  input  logic            tick_i,
  input  logic [CNTW-1:0] line_cnt_i,
  output logic [NK-1:0]   keys_o,
  output logic            changed_o
);
  logic [NL-1:0] stable, used, act;

  for (genvar g = 0; g < NL; g++) begin : g_mask
    assign used[g] = (CNTW'(g) < line_cnt_i);
  end
  assign act = stable & used;

  keymx_debounce #(.NL(NL), .STABLE_TICKS(STABLE_TICKS)) u_deb (
    .clk_i, .rst_ni, .tick_i, .raw_i(lines_i), .stable_o(stable)
  );

  keymx_chord #(.NL(NL), .NK(NK)) u_chord (
    .clk_i, .rst_ni, .act_i(act), .keys_o, .changed_o
  );

  assert_masked_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_cnt_i == '0) |=> (keys_o == '0));
endmodule

// File: tb/keymx_decoder_test.sv
module keymx_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  lines = '0;
  logic        tick = 1'b0;
  logic [2:0]  line_cnt = 3'd6;
  logic [20:0] keys;
  logic        changed;

  int checks = 0, failures = 0;
  logic [20:0] exp_q[$];
  bit   done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  keymx_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .lines_i(lines), .tick_i(tick),
    .line_cnt_i(line_cnt), .keys_o(keys), .changed_o(changed)
  );

  task automatic check(bit ok, string req, logic [20:0] act, logic [20:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop expected word on each change flag; flag must not last 2 clocks
  bit chg_prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (changed && chg_prev) check(0, "R10 flag wider than one clock", 21'(changed), 21'(0));
      if (changed) begin
        if (exp_q.size() == 0) check(0, "R10 unexpected change", keys, '0);
        else begin
          logic [20:0] e;
          e = exp_q.pop_front();
          check(keys == e, "R4-R9 status word", keys, e);
        end
      end
      chg_prev = changed;
    end
  end

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  // drive a line pattern, accept it, expect either a change to exp or no change
  task automatic step(logic [5:0] l, bit chg, logic [20:0] exp, string req);
    @(negedge clk) lines = l;
    if (chg) exp_q.push_back(exp);
    ticks(3);
    check(keys == exp, req, keys, exp);
    check(exp_q.size() == 0, {req, " pending change"}, 21'(exp_q.size()), '0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(0, "watchdog", '0, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(keys == '0 && !changed, "R1 reset", keys, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(keys == '0 && !changed, "R1 after reset", keys, '0);

    // R2: two ticks then back -> ignored; exactly 3 ticks needed
    @(negedge clk) lines = 6'b000010;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk) tick = 1; @(negedge clk) tick = 0;
    end
    check(keys == '0, "R2 not yet accepted", keys, '0);
    @(negedge clk) lines = '0;
    ticks(3);
    check(keys == '0, "R2 glitch ignored", keys, '0);

    // R4 single
    step(6'b000100, 1, 21'h1 << 2, "R4 press line 2");
    step(6'b000000, 1, '0, "R4 release line 2");
    // R5 pairs
    step(6'b001010, 1, 21'h1 << 12, "R5 pair (1,3)");
    step(6'b000000, 1, '0, "R9 release pair");
    step(6'b110000, 1, 21'h1 << 20, "R5 pair (4,5)");
    step(6'b000000, 1, '0, "R9 release pair");
    step(6'b000011, 1, 21'h1 << 6, "R5 pair (0,1)");
    step(6'b000000, 1, '0, "R9 release pair");
    // R6 sequential presses
    step(6'b000001, 1, 21'h1, "R6 press 0");
    step(6'b010001, 1, 21'h11, "R6 press 4 while 0 held");
    step(6'b000001, 1, 21'h1, "R6 release 4");
    step(6'b000000, 1, '0, "R6 release 0");
    // R8 three at once -> lowest pair (2,4), later press ignored
    step(6'b110100, 1, 21'h1 << 16, "R8 three together");
    step(6'b110101, 0, 21'h1 << 16, "R8 press while locked ignored");
    step(6'b110001, 0, 21'h1 << 16, "R9 one pair line still held");
    step(6'b100001, 1, '0, "R9 both pair lines released");
    step(6'b000000, 0, '0, "R9 all released");
    step(6'b001000, 1, 21'h1 << 3, "R9 lock released, single seen");
    step(6'b000000, 1, '0, "R4 release 3");
    // R3 line mask
    @(negedge clk) line_cnt = 3'd3;
    step(6'b100000, 0, '0, "R3 masked line ignored");
    exp_q.push_back(21'h1 << 5);
    @(negedge clk) line_cnt = 3'd6;
    repeat (4) @(negedge clk);
    check(keys == (21'h1 << 5), "R3 unmasked held line", keys, 21'h1 << 5);
    step(6'b000000, 1, '0, "R3 release");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule